// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address for a four-beat burst in front of a pipelined synchronous memory. A start address is captured when the access is selected and either of two active-low address strobes is asserted. One strobe comes from the processor side and one from the cache-controller side, and both behave the same here. The capture also clears an internal beat counter. On later cycles an active-low advance input either moves the two low address bits to the next beat or holds them, which suspends the burst. The bits above the beat field stay as they were captured until the next load.

A mode input chooses the beat order. With mode high the order is interleaved: the low bits are the start bits XOR the beat count. With mode low the order is linear: the start bits plus the beat count, wrapping inside the group of four. The address is registered, and a flag marks the fourth beat of the group.

A small state machine tracks the burst. BS_IDLE is the state after reset, before any load. BS_RUN means the last cycle loaded or stepped. BS_SUSP means the last cycle held. The transitions are:
- LOAD: any state to BS_RUN on a qualified strobe.
- STEP: BS_RUN or BS_SUSP to BS_RUN when advance is asserted.
- PAUSE: BS_RUN or BS_SUSP to BS_SUSP when advance is not asserted.
- STAY: BS_IDLE to BS_IDLE when there is no load.
- RESET: any state to BS_IDLE.

Top module: `burst_seq_top`

## Requirements
- R1: A synchronous reset, active high, sets addr_out to zero and last_beat low at the next clock edge.
- R2: When sel is 1 and either strobe is 0, the next edge loads addr_out with addr_in and the beat count restarts at 0.
- R3: A strobe asserted while sel is 0 loads nothing, and the address stays where it was.
- R4: With ilv_mode = 1, beat k of a burst has low bits equal to start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R5: With ilv_mode = 0, beat k has low bits equal to (start + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R6: With no load and adv_n = 1, addr_out holds its value (suspend). With adv_n = 0 it steps one beat.
- R7: An advance from the fourth beat returns the low bits to the start value. No carry reaches the upper bits.
- R8: Bits above the two low bits change only on a load.
- R9: last_beat is 1 exactly when the beat count is 3, which is the fourth beat.
- R10: After reset and before the first load (BS_IDLE), adv_n = 0 has no effect on addr_out.
- R11: A load in the same cycle as an advance loads, and does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Access selected; qualifies both strobes |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Start address |
| addr_out | output | ADDR_W | Registered burst address |
| last_beat | output | 1 | High on the fourth beat of the group |

## Verification
The bench builds the block with ADDR_W = 10. The eight upper bits are then short enough to carry distinct, recognisable patterns through every burst, so any carry out of the beat field or any stray upper-bit update shows up at once. The beat field is fixed at two bits by the package. Each of the four start values is therefore swept in both orders, including the wrap past the fourth beat. Suspends, simultaneous load and advance, and advances before the first load are mixed into the same run.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_RUN  = 2'd1,
        BS_SUSP = 2'd2
    } bs_state_t;
endpackage

// File: rtl/burst_seq_order.sv
module burst_seq_order #(
    parameter int BW = 2
) (
    input  logic [BW-1:0] start,
    input  logic [BW-1:0] count,
    input  logic          ilv,
    output logic [BW-1:0] beat
);
    logic [BW-1:0] xor_beat;
    logic [BW-1:0] lin_beat;

    for (genvar i = 0; i < BW; i++) begin : g_ilv_bit
        assign xor_beat[i] = start[i] ^ count[i];
    end

    assign lin_beat = start + count;
    assign beat     = ilv ? xor_beat : lin_beat;
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_req,
    input  logic adv_n,
    output logic step_en
);
    bs_state_t state_q;
    bs_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: state_d = load_req ? BS_RUN : BS_IDLE;
            BS_RUN,
            BS_SUSP: begin
                if (load_req)    state_d = BS_RUN;
                else if (!adv_n) state_d = BS_RUN;
                else             state_d = BS_SUSP;
            end
            default: state_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= BS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        step_en = 1'b0;
        unique case (state_q)
            BS_IDLE: step_en = 1'b0;
            BS_RUN,
            BS_SUSP: step_en = !load_req && !adv_n;
            default: step_en = 1'b0;
        endcase
    end

    // R10: no step may be taken in the cycle after reset
    a_r10_no_step_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !step_en);
endmodule

// File: rtl/burst_seq_beat.sv
module burst_seq_beat #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          ilv,
    input  logic [BW-1:0] load_low,
    output logic [BW-1:0] low_q,
    output logic          last
);
    logic [BW-1:0] start_q;
    logic [BW-1:0] cnt_q;
    logic [BW-1:0] cnt_nxt;
    logic [BW-1:0] beat_nxt;

    assign cnt_nxt = cnt_q + 1'b1;

    burst_seq_order #(.BW(BW)) u_order (
        .start (start_q),
        .count (cnt_nxt),
        .ilv   (ilv),
        .beat  (beat_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            cnt_q   <= '0;
            low_q   <= '0;
        end else if (load) begin
            start_q <= load_low;
            cnt_q   <= '0;
            low_q   <= load_low;
        end else if (step) begin
            cnt_q   <= cnt_nxt;
            low_q   <= beat_nxt;
        end
    end

    assign last = (cnt_q == {BW{1'b1}});

    // R5: a linear step moves the low bits up by one, modulo the group
    a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !ilv) |=> (low_q == BW'($past(low_q) + 1'b1)));

    // R7: stepping from the last beat returns to the start value
    a_r7_wrap_to_start: assert property (@(posedge clk) disable iff (rst)
        (step && !load && last) |=> (low_q == start_q));
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              ilv_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              last_beat
);
    localparam int BW = burst_seq_pkg::BEAT_W;
    localparam int UW = ADDR_W - BW;

    logic          load_req;
    logic          step_en;
    logic [BW-1:0] low_q;
    logic [UW-1:0] upper_q;

    assign load_req = sel && !(strb_cpu_n && strb_ctl_n);

    burst_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load_req (load_req),
        .adv_n    (adv_n),
        .step_en  (step_en)
    );

    burst_seq_beat #(.BW(BW)) u_beat (
        .clk      (clk),
        .rst      (rst),
        .load     (load_req),
        .step     (step_en),
        .ilv      (ilv_mode),
        .load_low (addr_in[BW-1:0]),
        .low_q    (low_q),
        .last     (last_beat)
    );

    always_ff @(posedge clk) begin
        if (rst)           upper_q <= '0;
        else if (load_req) upper_q <= addr_in[ADDR_W-1:BW];
    end

    assign addr_out = {upper_q, low_q};

    // R1: reset clears the address and the beat flag
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && !last_beat));

    // R2: a qualified strobe captures the input address
    a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
        load_req |=> (addr_out == $past(addr_in)));

    // R6: without load or advance the address is held
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_req && adv_n) |=> $stable(addr_out));

    // R8: upper bits move only on a load
    a_r8_upper_stable: assert property (@(posedge clk) disable iff (rst)
        !load_req |=> $stable(addr_out[ADDR_W-1:BW]));
endmodule

// File: tb/tb_burst_seq_top.sv
module tb_burst_seq_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel;
    logic          strb_cpu_n;
    logic          strb_ctl_n;
    logic          adv_n;
    logic          ilv_mode;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          last_beat;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    int m_up    = 0;
    int m_start = 0;
    int m_cnt   = 0;
    int m_low   = 0;
    bit m_act   = 0;

    always #5 clk = ~clk;

    burst_seq_top #(.ADDR_W(AW)) dut (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .ilv_mode   (ilv_mode),
        .addr_in    (addr_in),
        .addr_out   (addr_out),
        .last_beat  (last_beat)
    );

    task automatic step(input logic r, input logic s, input logic a_n, input logic b_n,
                        input logic av_n, input logic md, input int ad, input string tag);
        int exp_addr;
        bit exp_last;
        rst = r; sel = s; strb_cpu_n = a_n; strb_ctl_n = b_n;
        adv_n = av_n; ilv_mode = md; addr_in = AW'(ad);
        @(posedge clk);
        if (r) begin
            m_up = 0; m_start = 0; m_cnt = 0; m_low = 0; m_act = 0;
        end else if (s && (!a_n || !b_n)) begin
            m_up = (ad >> 2) & 8'hFF; m_start = ad & 3; m_cnt = 0;
            m_low = m_start; m_act = 1;
        end else if (!av_n && m_act) begin
            m_cnt = (m_cnt + 1) % 4;
            m_low = md ? (m_start ^ m_cnt) : ((m_start + m_cnt) % 4);
        end
        @(negedge clk);
        exp_addr = (m_up << 2) | m_low;
        exp_last = (m_cnt == 3);
        n_cmp++;
        if (addr_out !== AW'(exp_addr) || last_beat !== exp_last) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h last_beat=%b expected addr_out=%h last_beat=%b",
                     tag, addr_out, last_beat, AW'(exp_addr), exp_last);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        step(1, 0, 1, 1, 1, 1, 0, "R1");
        step(1, 0, 1, 1, 1, 1, 0, "R1");
        // R10: advance before any load
        step(0, 0, 1, 1, 0, 1, 0, "R10");
        step(0, 0, 1, 1, 0, 1, 0, "R10");
        // R3: strobe while not selected
        step(0, 0, 0, 0, 1, 1, 10'h155, "R3");
        // R2: load via processor strobe, interleaved burst
        step(0, 1, 0, 1, 1, 1, {8'hA5, 2'b01}, "R2");
        step(0, 0, 1, 1, 0, 1, 0, "R4");
        step(0, 0, 1, 1, 0, 1, 0, "R4");
        step(0, 0, 1, 1, 0, 1, 0, "R9");
        step(0, 0, 1, 1, 0, 1, 0, "R7");
        // R6: suspend
        step(0, 0, 1, 1, 1, 1, 0, "R6");
        step(0, 0, 1, 1, 1, 1, 0, "R6");
        step(0, 0, 1, 1, 0, 1, 0, "R6");
        // R3 mid-burst: unselected strobe must not reload
        step(0, 0, 1, 0, 1, 1, 10'h3FF, "R3");
        // R2: load via controller strobe, linear burst
        step(0, 1, 1, 0, 1, 0, {8'h3C, 2'b10}, "R2");
        step(0, 0, 1, 1, 0, 0, 0, "R5");
        step(0, 0, 1, 1, 0, 0, 0, "R5");
        step(0, 0, 1, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 1, 0, 0, 0, "R7");
        step(0, 0, 1, 1, 0, 0, 0, "R8");
        // R11: load together with advance
        step(0, 1, 0, 0, 0, 0, {8'h81, 2'b11}, "R11");
        step(0, 1, 0, 1, 0, 0, {8'h42, 2'b00}, "R11");
        step(0, 0, 1, 1, 0, 0, 0, "R5");
        // R1: reset mid-burst, then R10 again
        step(1, 0, 1, 1, 0, 0, 0, "R1");
        step(0, 0, 1, 1, 0, 0, 0, "R10");
        // sweep all starts in both orders, with wrap
        for (int md = 0; md < 2; md++) begin
            for (int st = 0; st < 4; st++) begin
                step(0, 1, st[0], !st[0], 1, md[0], ((st * 37 + md * 91 + 5) << 2 | st) & 10'h3FF, "R2");
                for (int k = 0; k < 5; k++)
                    step(0, 0, 1, 1, 0, md[0], 0, md ? "R4" : "R5");
                step(0, 0, 1, 1, 1, md[0], 0, "R8");
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule